// File: doc/BRIEF.md
# Serial-Bus Front End for a Two-Input Sampling Converter

This block is the two-wire serial slave that sits in front of a small sampling converter. It watches the clock and data lines of an I2C bus through synchronisers running on the system clock. The pins are open-drain: the block pulls a line low through an output enable and never drives it high. The block answers to one fixed 7-bit address. It stores written bytes into one of two control registers, chosen by the top bit of each byte. It also notices the high-speed master code and keeps track of the bus speed mode that the code selects.

When the master reads, the block paces the converter.

- **External-clock mode.** Track, hold and convert indications follow SCL rising edges. After the hold edge the converter runs for a fixed number of SCL cycles.
- **Internal-clock mode.** The block holds SCL low after the address acknowledge. It releases SCL when the converter model reports done, or when a parameterised count of system clocks has elapsed.

In both modes the captured 12-bit result is sent MSB first in two bytes. The first byte is padded with leading ones.

Top module: `i2c_adc_ctrl`

## Requirements
- R1: After a START, the block compares the first 7 received bits with DEV_ADDR. On a match it pulls SDA low during the 9th clock, and it does the same after every written data byte. On a mismatch it never pulls SDA low and stores nothing until the next START.
- R2: A written byte whose bit 7 is 1 is stored in setup_q. A written byte whose bit 7 is 0 is stored in config_q. The other register keeps its value.
- R3: config_q bits 6:5 appear on scan_sel, bit 1 on chan_sel, and bit 0 on single_ended.
- R4: An address byte whose top five bits are 00001 is a master code. It is not acknowledged, it sets hs_mode to 1, and a STOP clears hs_mode to 0.
- R5: A read returns {1111, result[11:8]} first and result[7:0] second, each MSB first. While the master keeps acknowledging, the two bytes repeat.
- R6: After the master leaves the acknowledge slot of a read byte high (NACK), SDA is never pulled low again until the next START.
- R7: With setup_q bit 3 equal to 0 (external-clock mode), track pulses for one cycle at the 8th SCL rising edge (the R/W bit) of a matching read address.
- R8: In external-clock mode, hold pulses and result is captured at the second SCL rising edge of the first result byte. convert then stays high and drops at the 12th SCL rising edge after hold.
- R9: With setup_q bit 3 equal to 1 (internal-clock mode), the block pulls SCL low from the falling edge that ends the read-address acknowledge. It lets SCL go when conv_done is seen or when CONV_CLKS system clocks have elapsed, whichever comes first. It captures result at that release.
- R10: A START or repeated START in the middle of a byte discards the partial byte and restarts address matching.
- R11: After reset, scl_oe, sda_oe, track, hold, convert and hs_mode are 0, and setup_q and config_q are 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low |
| result | input | RES_W | Conversion result from the converter model |
| conv_done | input | 1 | Converter model finished (internal-clock mode) |
| setup_q | output | 8 | Stored setup byte |
| config_q | output | 8 | Stored configuration byte |
| scan_sel | output | 2 | Scan-select field of the configuration byte |
| chan_sel | output | 1 | Channel select |
| single_ended | output | 1 | Single-ended (1) or differential (0) select |
| hs_mode | output | 1 | High-speed bus mode active |
| track | output | 1 | Track strobe |
| hold | output | 1 | Hold strobe |
| convert | output | 1 | Conversion in progress |

## Verification
On every cycle the assertions check several local rules:
- the slave pulls SDA low only while SCL is low;
- track and hold never coincide;
- STOP always leaves high-speed mode;
- the configuration register changes only on a write of a byte with bit 7 clear;
- hold in external-clock mode starts a conversion;
- done ends a conversion in internal-clock mode.

Only the bench scenarios can show the things that depend on whole transfers. These are the SCL edge numbers at which track, hold and the end of convert fall, the byte framing of the result, the length of the clock stretch, and that a mismatched address or a NACK keeps SDA released. They also cover a repeated START discarding a partial byte.

// File: rtl/adci_pkg.sv
package adci_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ACK, ST_WR, ST_STRETCH, ST_RD, ST_RD_ACK, ST_IGNORE
  } adci_state_e;

  localparam int unsigned BYTE_W        = 8;
  localparam int unsigned SETUP_CLK_BIT = 3;

  function automatic logic is_master_code(input logic [BYTE_W-1:0] b);
    return b[7:3] == 5'b00001;
  endfunction
endpackage

// File: rtl/adci_line_sync.sv
module adci_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int unsigned LINES = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] synced;
  logic [LINES-1:0] prev;

  assign raw = {sda_i, scl_i};

  genvar g;
  for (g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= '1;
      else     sh <= {sh[STAGES-2:0], raw[g]};
    end
    assign synced[g] = sh[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev      <= '1;
      scl_s     <= 1'b1;
      sda_s     <= 1'b1;
      scl_rise  <= 1'b0;
      scl_fall  <= 1'b0;
      start_det <= 1'b0;
      stop_det  <= 1'b0;
    end else begin
      prev      <= synced;
      scl_s     <= synced[0];
      sda_s     <= synced[1];
      scl_rise  <= synced[0] & ~prev[0];
      scl_fall  <= ~synced[0] & prev[0];
      start_det <= synced[0] & prev[0] & prev[1] & ~synced[1];
      stop_det  <= synced[0] & prev[0] & ~prev[1] & synced[1];
    end
  end
endmodule

// File: rtl/adci_ctrl_regs.sv
module adci_ctrl_regs
  import adci_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              mc_stb,
  input  logic              stop_stb,
  output logic [BYTE_W-1:0] setup_q,
  output logic [BYTE_W-1:0] config_q,
  output logic              hs_mode
);
  always_ff @(posedge clk) begin
    if (rst) begin
      setup_q  <= '0;
      config_q <= '0;
      hs_mode  <= 1'b0;
    end else begin
      if (wr_stb) begin
        if (wr_byte[BYTE_W-1]) setup_q  <= wr_byte;
        else                   config_q <= wr_byte;
      end
      if (stop_stb)    hs_mode <= 1'b0;
      else if (mc_stb) hs_mode <= 1'b1;
    end
  end

  assert_hs_cleared_R4: assert property (@(posedge clk) disable iff (rst)
    stop_stb |=> !hs_mode);

  assert_cfg_guard_R2: assert property (@(posedge clk) disable iff (rst)
    !(wr_stb && !wr_byte[BYTE_W-1]) |=> $stable(config_q));
endmodule

// File: rtl/adci_conv_seq.sv
module adci_conv_seq #(
  parameter int unsigned CONV_SCL  = 12,
  parameter int unsigned CONV_CLKS = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_go,
  input  logic int_go,
  input  logic abort,
  input  logic scl_rise,
  input  logic conv_done,
  output logic hold,
  output logic convert,
  output logic int_release
);
  localparam int unsigned SW = $clog2(CONV_SCL + 1);
  localparam int unsigned CW = $clog2(CONV_CLKS + 1);

  logic          mode_int;
  logic [SW-1:0] rise_cnt;
  logic [CW-1:0] clk_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold        <= 1'b0;
      convert     <= 1'b0;
      int_release <= 1'b0;
      mode_int    <= 1'b0;
      rise_cnt    <= '0;
      clk_cnt     <= '0;
    end else begin
      hold        <= 1'b0;
      int_release <= 1'b0;
      if (abort) begin
        convert <= 1'b0;
      end else if (ext_go) begin
        hold     <= 1'b1;
        convert  <= 1'b1;
        mode_int <= 1'b0;
        rise_cnt <= '0;
      end else if (int_go) begin
        hold     <= 1'b1;
        convert  <= 1'b1;
        mode_int <= 1'b1;
        clk_cnt  <= '0;
      end else if (convert && !mode_int) begin
        if (scl_rise) begin
          if (rise_cnt == SW'(CONV_SCL - 1)) convert <= 1'b0;
          rise_cnt <= rise_cnt + 1'b1;
        end
      end else if (convert && mode_int) begin
        if (conv_done || clk_cnt == CW'(CONV_CLKS - 1)) begin
          convert     <= 1'b0;
          int_release <= 1'b1;
        end
        clk_cnt <= clk_cnt + 1'b1;
      end
    end
  end

  assert_hold_starts_conv_R8: assert property (@(posedge clk) disable iff (rst)
    (ext_go && !abort) |=> (hold && convert));

  assert_done_releases_R9: assert property (@(posedge clk) disable iff (rst)
    (convert && mode_int && conv_done && !abort && !ext_go && !int_go) |=> (int_release && !convert));
endmodule

// File: rtl/i2c_adc_ctrl.sv
module i2c_adc_ctrl
  import adci_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h36,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RES_W       = 12,
  parameter int unsigned CONV_SCL    = 12,
  parameter int unsigned CONV_CLKS   = 200
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_oe,
  output logic             sda_oe,
  input  logic [RES_W-1:0] result,
  input  logic             conv_done,
  output logic [7:0]       setup_q,
  output logic [7:0]       config_q,
  output logic [1:0]       scan_sel,
  output logic             chan_sel,
  output logic             single_ended,
  output logic             hs_mode,
  output logic             track,
  output logic             hold,
  output logic             convert
);
  localparam int unsigned FRAME_W = 2 * BYTE_W;
  localparam int unsigned PAD_W   = FRAME_W - RES_W;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_stb, mc_stb, ext_go, int_go, int_release;
  logic [BYTE_W-1:0] wr_byte;

  adci_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  adci_ctrl_regs u_regs (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_byte(wr_byte),
    .mc_stb(mc_stb), .stop_stb(stop_det),
    .setup_q(setup_q), .config_q(config_q), .hs_mode(hs_mode)
  );

  adci_conv_seq #(.CONV_SCL(CONV_SCL), .CONV_CLKS(CONV_CLKS)) u_seq (
    .clk(clk), .rst(rst), .ext_go(ext_go), .int_go(int_go),
    .abort(start_det | stop_det), .scl_rise(scl_rise), .conv_done(conv_done),
    .hold(hold), .convert(convert), .int_release(int_release)
  );

  assign scan_sel     = config_q[6:5];
  assign chan_sel     = config_q[1];
  assign single_ended = config_q[0];

  adci_state_e       state;
  logic [3:0]        cnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] in_byte;
  logic              rd_mode, ack_on, byte_sel, hold_pend, got_ack;
  logic [RES_W-1:0]  res_q;
  logic [FRAME_W-1:0] frame;
  logic              int_clk;

  assign in_byte = {shreg[BYTE_W-2:0], sda_s};
  assign frame   = {{PAD_W{1'b1}}, res_q};
  assign int_clk = setup_q[SETUP_CLK_BIT];

  function automatic logic tx_bit(input logic sel, input logic [2:0] idx,
                                  input logic [FRAME_W-1:0] f);
    logic [BYTE_W-1:0] b;
    b = sel ? f[BYTE_W-1:0] : f[FRAME_W-1:BYTE_W];
    return b[3'd7 - idx];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      shreg     <= '0;
      rd_mode   <= 1'b0;
      ack_on    <= 1'b0;
      byte_sel  <= 1'b0;
      hold_pend <= 1'b0;
      got_ack   <= 1'b0;
      res_q     <= '0;
      sda_oe    <= 1'b0;
      scl_oe    <= 1'b0;
      track     <= 1'b0;
      wr_stb    <= 1'b0;
      wr_byte   <= '0;
      mc_stb    <= 1'b0;
      ext_go    <= 1'b0;
      int_go    <= 1'b0;
    end else begin
      track  <= 1'b0;
      wr_stb <= 1'b0;
      mc_stb <= 1'b0;
      ext_go <= 1'b0;
      int_go <= 1'b0;
      if (start_det) begin
        state     <= ST_ADDR;
        cnt       <= '0;
        sda_oe    <= 1'b0;
        scl_oe    <= 1'b0;
        hold_pend <= 1'b0;
      end else if (stop_det) begin
        state     <= ST_IDLE;
        sda_oe    <= 1'b0;
        scl_oe    <= 1'b0;
        hold_pend <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE, ST_IGNORE: ;
          ST_ADDR: begin
            if (scl_rise) begin
              shreg <= in_byte;
              if (cnt == 4'd7) begin
                cnt <= '0;
                if (is_master_code(in_byte)) begin
                  mc_stb <= 1'b1;
                  state  <= ST_IGNORE;
                end else if (in_byte[7:1] == DEV_ADDR) begin
                  rd_mode <= in_byte[0];
                  ack_on  <= 1'b0;
                  state   <= ST_ACK;
                  if (in_byte[0] && !int_clk) track <= 1'b1;
                end else begin
                  state <= ST_IGNORE;
                end
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              if (!ack_on) begin
                sda_oe <= 1'b1;
                ack_on <= 1'b1;
              end else begin
                ack_on <= 1'b0;
                cnt    <= '0;
                if (!rd_mode) begin
                  sda_oe <= 1'b0;
                  state  <= ST_WR;
                end else if (int_clk) begin
                  sda_oe <= 1'b0;
                  scl_oe <= 1'b1;
                  int_go <= 1'b1;
                  state  <= ST_STRETCH;
                end else begin
                  byte_sel  <= 1'b0;
                  hold_pend <= 1'b1;
                  sda_oe    <= ~tx_bit(1'b0, 3'd0, frame);
                  cnt       <= 4'd1;
                  state     <= ST_RD;
                end
              end
            end
          end
          ST_WR: begin
            if (scl_rise) begin
              shreg <= in_byte;
              if (cnt == 4'd7) begin
                wr_stb  <= 1'b1;
                wr_byte <= in_byte;
                ack_on  <= 1'b0;
                cnt     <= '0;
                state   <= ST_ACK;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          ST_STRETCH: begin
            if (int_release) begin
              scl_oe   <= 1'b0;
              res_q    <= result;
              byte_sel <= 1'b0;
              sda_oe   <= ~tx_bit(1'b0, 3'd0, {{PAD_W{1'b1}}, result});
              cnt      <= 4'd1;
              state    <= ST_RD;
            end
          end
          ST_RD: begin
            if (scl_rise && hold_pend && cnt == 4'd2) begin
              ext_go    <= 1'b1;
              hold_pend <= 1'b0;
              res_q     <= result;
            end
            if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0;
                state  <= ST_RD_ACK;
              end else begin
                sda_oe <= ~tx_bit(byte_sel, cnt[2:0], frame);
                cnt    <= cnt + 1'b1;
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) got_ack <= ~sda_s;
            if (scl_fall) begin
              if (got_ack) begin
                byte_sel <= ~byte_sel;
                sda_oe   <= ~tx_bit(~byte_sel, 3'd0, frame);
                cnt      <= 4'd1;
                state    <= ST_RD;
              end else begin
                state <= ST_IGNORE;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assert_sda_pull_scl_low_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_s);

  assert_track_hold_apart_R7: assert property (@(posedge clk) disable iff (rst)
    !(track && hold));

  assert_stretch_only_int_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(scl_oe) |-> int_clk);
endmodule

// File: tb/i2c_adc_ctrl_test.sv
module i2c_adc_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 6;
  localparam int CONV_CLKS  = 60;
  localparam logic [6:0] ADDR = 7'h36;

  logic clk = 0;
  logic rst = 1;
  logic m_scl = 1, m_sda = 1;
  logic [11:0] result = '0;
  logic conv_done = 0;
  wire  scl_oe, sda_oe;
  wire  scl_bus = m_scl & ~scl_oe;
  wire  sda_bus = m_sda & ~sda_oe;
  logic [7:0] setup_q, config_q;
  logic [1:0] scan_sel;
  logic chan_sel, single_ended, hs_mode, track, hold, convert;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_adc_ctrl #(.DEV_ADDR(ADDR), .CONV_CLKS(CONV_CLKS)) uut (
    .clk(clk), .rst(rst), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .result(result), .conv_done(conv_done),
    .setup_q(setup_q), .config_q(config_q), .scan_sel(scan_sel),
    .chan_sel(chan_sel), .single_ended(single_ended), .hs_mode(hs_mode),
    .track(track), .hold(hold), .convert(convert)
  );

  int total = 0, bad = 0, printed = 0;
  logic [7:0] exp_setup = 0, exp_cfg = 0;
  logic exp_hs = 0;
  bit   cmp_en = 0;
  int   rise_no = 0, track_at = -1, hold_at = -1, conv_end_at = -1;
  int   last_wait = 0;
  bit   watch_sda = 0, sda_seen = 0, conv_prev = 0;
  int   done_delay = -1, done_cnt = -1;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      if (printed < 20) $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
      printed++;
    end
  endtask

  // per-clock reference comparison of stored state while the bus is quiet
  always @(negedge clk) begin
    if (cmp_en) begin
      check(setup_q == exp_setup, "R2 setup", setup_q, exp_setup);
      check(config_q == exp_cfg, "R2 config", config_q, exp_cfg);
      check(scan_sel == exp_cfg[6:5], "R3 scan", scan_sel, exp_cfg[6:5]);
      check({chan_sel, single_ended} == exp_cfg[1:0], "R3 chan/se",
            {chan_sel, single_ended}, exp_cfg[1:0]);
      check(hs_mode == exp_hs, "R4 hs", hs_mode, exp_hs);
    end
  end

  // strobe monitor and converter model
  always @(negedge clk) begin
    if (track) track_at = rise_no;
    if (hold) hold_at = rise_no;
    if (conv_prev && !convert) conv_end_at = rise_no;
    conv_prev = convert;
    if (watch_sda && sda_oe) sda_seen = 1;
    conv_done = 0;
    if (hold && done_delay >= 0) done_cnt = done_delay;
    else if (done_cnt > 0) done_cnt--;
    else if (done_cnt == 0) begin conv_done = 1; done_cnt = -1; end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic raise_scl();
    m_scl = 1;
    last_wait = 0;
    while (!scl_bus && last_wait < 5000) begin @(negedge clk); last_wait++; end
  endtask

  task automatic bus_start();
    m_sda = 1; m_scl = 1; wait_clk(Q);
    m_sda = 0; wait_clk(Q);
    m_scl = 0; wait_clk(Q);
    rise_no = 0;
  endtask

  task automatic bus_rstart();
    m_sda = 1; wait_clk(Q);
    raise_scl(); wait_clk(Q);
    m_sda = 0; wait_clk(Q);
    m_scl = 0; wait_clk(Q);
    rise_no = 0;
  endtask

  task automatic bus_stop();
    m_sda = 0; wait_clk(Q);
    raise_scl(); wait_clk(Q);
    m_sda = 1; wait_clk(Q);
  endtask

  task automatic put_bit(input logic b, output logic s);
    m_sda = b; wait_clk(Q);
    rise_no++;
    raise_scl(); wait_clk(Q);
    s = sda_bus; wait_clk(Q);
    m_scl = 0; wait_clk(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit ack);
    logic s;
    for (int i = 7; i >= 0; i--) put_bit(b[i], s);
    put_bit(1'b1, s);
    ack = !s;
  endtask

  task automatic rd_byte(input bit give_ack, output logic [7:0] b, output int first_wait);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      put_bit(1'b1, s);
      b[i] = s;
      if (i == 7) first_wait = last_wait;
    end
    put_bit(give_ack ? 1'b0 : 1'b1, s);
  endtask

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    wait_clk(150000);
    total++; bad++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    finish_up();
  end

  initial begin
    bit ack;
    logic [7:0] b0, b1, b2;
    int w, dummy;
    logic s;

    wait_clk(5);
    // R11 reset state
    check({scl_oe, sda_oe, track, hold, convert, hs_mode} == 6'b0, "R11 outputs",
          {scl_oe, sda_oe, track, hold, convert, hs_mode}, 0);
    check(setup_q == 8'h00 && config_q == 8'h00, "R11 regs", {setup_q, config_q}, 0);
    rst = 0;
    wait_clk(5);
    cmp_en = 1;

    // R1, R2, R3: multi-byte write routed by bit 7
    cmp_en = 0;
    bus_start();
    wr_byte({ADDR, 1'b0}, ack); check(ack, "R1 addr ack", ack, 1);
    wr_byte(8'h80, ack); check(ack, "R1 data ack", ack, 1); exp_setup = 8'h80;
    wr_byte(8'h63, ack); check(ack, "R1 data ack", ack, 1); exp_cfg = 8'h63;
    wr_byte(8'h41, ack); check(ack, "R1 data ack", ack, 1); exp_cfg = 8'h41;
    bus_stop(); wait_clk(4); cmp_en = 1;
    check(scan_sel == 2'b10 && chan_sel == 0 && single_ended == 1, "R3 decode",
          {scan_sel, chan_sel, single_ended}, 4'b1001);

    // R1 mismatch: no ack, nothing stored, SDA never pulled
    cmp_en = 0; sda_seen = 0; watch_sda = 1;
    bus_start();
    wr_byte({7'h35, 1'b0}, ack); check(!ack, "R1 mismatch nack", ack, 0);
    wr_byte(8'h2F, ack); check(!ack, "R1 mismatch data", ack, 0);
    bus_stop(); wait_clk(4); watch_sda = 0; cmp_en = 1;
    check(!sda_seen, "R1 sda released", sda_seen, 0);
    check(config_q == 8'h41, "R1 cfg kept", config_q, 8'h41);

    // R4 master code
    cmp_en = 0;
    bus_start();
    wr_byte(8'h0D, ack); check(!ack, "R4 mc nack", ack, 0);
    wait_clk(4); check(hs_mode, "R4 hs set", hs_mode, 1);
    exp_hs = 1;
    bus_rstart();
    wr_byte({ADDR, 1'b0}, ack); check(ack, "R4 hs addr ack", ack, 1);
    wr_byte(8'h05, ack); exp_cfg = 8'h05;
    check(hs_mode, "R4 hs kept", hs_mode, 1);
    bus_stop(); wait_clk(4); exp_hs = 0; cmp_en = 1;
    check(!hs_mode, "R4 hs cleared", hs_mode, 0);

    // R5 R6 R7 R8 external-clock read
    result = 12'hA5C; track_at = -1; hold_at = -1; conv_end_at = -1;
    bus_start();
    wr_byte({ADDR, 1'b1}, ack); check(ack, "R1 read ack", ack, 1);
    rd_byte(1, b0, dummy);
    rd_byte(1, b1, dummy);
    rd_byte(0, b2, dummy);
    check(b0 == 8'hFA, "R5 byte0", b0, 8'hFA);
    check(b1 == 8'h5C, "R5 byte1", b1, 8'h5C);
    check(b2 == 8'hFA, "R5 repeat", b2, 8'hFA);
    check(track_at == 8, "R7 track edge", track_at, 8);
    check(hold_at == 11, "R8 hold edge", hold_at, 11);
    check(conv_end_at == 23, "R8 convert end", conv_end_at, 23);
    sda_seen = 0; watch_sda = 1;
    for (int i = 0; i < 10; i++) put_bit(1'b1, s);
    watch_sda = 0;
    check(!sda_seen, "R6 released after nack", sda_seen, 0);
    bus_stop(); wait_clk(4);

    // R10 repeated start mid-byte
    cmp_en = 0;
    bus_start();
    wr_byte({ADDR, 1'b0}, ack);
    put_bit(1, s); put_bit(0, s); put_bit(0, s); put_bit(1, s);
    bus_rstart();
    wr_byte({ADDR, 1'b0}, ack); check(ack, "R10 restart ack", ack, 1);
    wr_byte(8'h22, ack); exp_cfg = 8'h22;
    bus_stop(); wait_clk(4); cmp_en = 1;
    check(config_q == 8'h22 && setup_q == 8'h80, "R10 partial dropped",
          {setup_q, config_q}, 16'h8022);

    // R9 internal-clock mode with done
    cmp_en = 0;
    bus_start();
    wr_byte({ADDR, 1'b0}, ack);
    wr_byte(8'h88, ack); exp_setup = 8'h88;
    bus_stop(); wait_clk(4); cmp_en = 1;
    result = 12'h3C1; done_delay = 20;
    bus_start();
    wr_byte({ADDR, 1'b1}, ack);
    rd_byte(1, b0, w);
    rd_byte(0, b1, dummy);
    bus_stop(); wait_clk(4);
    check(w >= 1 && w <= 30, "R9 stretch by done", w, 20);
    check(b0 == 8'hF3 && b1 == 8'hC1, "R9 data done", {b0, b1}, 16'hF3C1);

    // R9 internal-clock timeout
    result = 12'h7E0; done_delay = -1;
    bus_start();
    wr_byte({ADDR, 1'b1}, ack);
    rd_byte(1, b0, w);
    rd_byte(0, b1, dummy);
    bus_stop(); wait_clk(4);
    check(w >= CONV_CLKS - 20 && w <= CONV_CLKS + 10, "R9 stretch timeout", w, CONV_CLKS);
    check(b0 == 8'hF7 && b1 == 8'hE0, "R9 data timeout", {b0, b1}, 16'hF7E0);
    check(!scl_oe, "R9 scl released", scl_oe, 0);

    cmp_en = 0;
    finish_up();
  end
endmodule